// File: doc/BRIEF.md
# Byte-Framed SPI Configuration Register File

This block is an SPI slave (mode 0, MSB first) that turns a stream of 8-bit frames into writes to an 8-bit register space. Each chip-select assertion carries exactly one byte. A register write takes three frames in a row: the key byte 0xAA, then the register address, then the data byte. The SPI clock, chip-select and data lines are brought into the system clock domain through two-flop synchronisers. Bits are sampled on the synchronised rising edge of the SPI clock.

The register space holds the timing parameters of an acquisition sequencer. It also holds the gain DAC code, the ADC rate divisor, the continuous-mode cycle count, the single/continuous mode bit, and a 41-entry time-indexed gain table. The table has one byte per address from 0x10 to 0x38. Wider parameters are built from two or three byte addresses and are presented assembled. Two command addresses do not keep a value: a write to either one gives a one-cycle strobe on a dedicated output. A downstream gain sequencer reads the gain table through a combinational index port.

Top module: `spi_cfg_regs`

## Requirements
- R1: After reset the outputs are: pulse_on_len=0x14, on_off_gap=0x0A, pulse_off_len=0x00C8, off_acq_delay=0x02BC, acq_len=0x32C8, cycle_period=0x0186A0, cont_mode=0, gain_dac=0x11, adc_rate_div=0x03, burst_count=0x0A, both strobes 0, and every gain table entry 0.
- R2: A frame is the 8 bits sampled on the rising SPI clock edges while cs_n is low, MSB first. A write is the key 0xAA, then an address byte, then a data byte, each in its own frame. The written output changes on the 4th clk rising edge after the SPI clock edge that completes the data byte.
- R3: When the state machine is waiting for the key, any complete byte other than 0xAA is discarded and the machine keeps waiting for 0xAA.
- R4: Raising cs_n before 8 bits have been sampled discards the partial byte. The next frame starts a fresh byte, and the state of the write sequence does not change.
- R5: Address 0xE0 sets pulse_on_len and 0xD0 sets on_off_gap. The 16-bit parameters are split into MSB/LSB pairs: pulse_off_len is 0xE1/0xE2, off_acq_delay is 0xE3/0xE4, and acq_len is 0xE5/0xE6. Each byte write updates only its own half.
- R6: cycle_period is 24 bits: 0xE7 holds bits 23:16, 0xE8 holds bits 15:8, and 0xE9 holds bits 7:0.
- R7: A write of any data to 0xEA raises sw_trig for exactly one clk cycle. A write to 0xEF does the same for mem_ptr_clr. Neither output is high at any other time.
- R8: Address 0xEB stores data bit 0 as cont_mode (0 means single, 1 means continuous). The other data bits are ignored.
- R9: Addresses 0xEC, 0xED and 0xEE set gain_dac, adc_rate_div and burst_count.
- R10: Address 0x10+k (k from 0 to 40) writes gain table entry k. gt_data returns entry gt_idx while gt_idx is 40 or less, and 0 for higher indices.
- R11: A write to any address not listed above changes no output. After the data byte the machine waits for 0xAA again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI clock (asynchronous) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI serial data in |
| gt_idx | input | 6 | Gain table read index |
| gt_data | output | 8 | Gain table entry at gt_idx |
| pulse_on_len | output | 8 | On-pulse length |
| on_off_gap | output | 8 | Gap from on pulse to off pulse |
| pulse_off_len | output | 16 | Off-pulse length |
| off_acq_delay | output | 16 | Delay from off pulse to acquisition |
| acq_len | output | 16 | Acquisition length |
| cycle_period | output | 24 | Period of one cycle |
| cont_mode | output | 1 | 0 single, 1 continuous |
| gain_dac | output | 8 | Gain DAC code |
| adc_rate_div | output | 8 | ADC rate divisor |
| burst_count | output | 8 | Cycles in continuous mode |
| sw_trig | output | 1 | One-cycle software trigger strobe |
| mem_ptr_clr | output | 1 | One-cycle memory pointer reset strobe |

## Verification
Every written output is due exactly four clk edges after the SPI clock edge that completes the data byte. That delay is two synchroniser stages, the edge-detect stage and the byte-capture register. A strobe is high only in the cycle after that edge. The bench drives each SPI edge on a falling clk edge and gives every completed write a countdown of four falling edges in its reference model. It compares all outputs on every falling edge, so an output that changes one cycle early or late, or a strobe that lasts two cycles, is a mismatch. gt_data is combinational, so its index changes on one falling edge and the result is checked on the next.

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int         GT_N    = 41,
  parameter int         IW      = 6,
  parameter logic [7:0] KEY     = 8'hAA,
  parameter logic [7:0] GT_BASE = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [IW-1:0] gt_idx,
  output logic [7:0]    gt_data,
  output logic [7:0]    pulse_on_len,
  output logic [7:0]    on_off_gap,
  output logic [15:0]   pulse_off_len,
  output logic [15:0]   off_acq_delay,
  output logic [15:0]   acq_len,
  output logic [23:0]   cycle_period,
  output logic          cont_mode,
  output logic [7:0]    gain_dac,
  output logic [7:0]    adc_rate_div,
  output logic [7:0]    burst_count,
  output logic          sw_trig,
  output logic          mem_ptr_clr
);

  typedef enum logic [1:0] {ST_KEY, ST_ADR, ST_DAT} st_t;

  logic [2:0] sck_s;
  logic [1:0] cs_s, mo_s;
  logic [2:0] bcnt;
  logic [6:0] sh;
  logic [7:0] rx, adr;
  logic       rx_v;
  st_t        st;
  logic [7:0] gt [GT_N];

  wire cs_act   = ~cs_s[1];
  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire wr       = rx_v && (st == ST_DAT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      cs_s  <= 2'b11;
      mo_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      cs_s  <= {cs_s[0], cs_n};
      mo_s  <= {mo_s[0], mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bcnt <= '0;
      sh   <= '0;
      rx   <= '0;
      rx_v <= 1'b0;
    end else begin
      rx_v <= 1'b0;
      if (!cs_act) bcnt <= '0;
      else if (sck_rise) begin
        sh   <= {sh[5:0], mo_s[1]};
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          rx   <= {sh, mo_s[1]};
          rx_v <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ST_KEY;
      adr <= '0;
    end else if (rx_v) begin
      unique case (st)
        ST_KEY:  if (rx == KEY) st <= ST_ADR;
        ST_ADR:  begin adr <= rx; st <= ST_DAT; end
        default: st <= ST_KEY;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pulse_on_len  <= 8'h14;
      on_off_gap    <= 8'h0A;
      pulse_off_len <= 16'h00C8;
      off_acq_delay <= 16'h02BC;
      acq_len       <= 16'h32C8;
      cycle_period  <= 24'h0186A0;
      cont_mode     <= 1'b0;
      gain_dac      <= 8'h11;
      adc_rate_div  <= 8'h03;
      burst_count   <= 8'h0A;
      sw_trig       <= 1'b0;
      mem_ptr_clr   <= 1'b0;
    end else begin
      sw_trig     <= wr && (adr == 8'hEA);
      mem_ptr_clr <= wr && (adr == 8'hEF);
      if (wr) begin
        case (adr)
          8'hE0: pulse_on_len         <= rx;
          8'hD0: on_off_gap           <= rx;
          8'hE1: pulse_off_len[15:8]  <= rx;
          8'hE2: pulse_off_len[7:0]   <= rx;
          8'hE3: off_acq_delay[15:8]  <= rx;
          8'hE4: off_acq_delay[7:0]   <= rx;
          8'hE5: acq_len[15:8]        <= rx;
          8'hE6: acq_len[7:0]         <= rx;
          8'hE7: cycle_period[23:16]  <= rx;
          8'hE8: cycle_period[15:8]   <= rx;
          8'hE9: cycle_period[7:0]    <= rx;
          8'hEB: cont_mode            <= rx[0];
          8'hEC: gain_dac             <= rx;
          8'hED: adc_rate_div         <= rx;
          8'hEE: burst_count          <= rx;
          default: ;
        endcase
      end
    end

  for (genvar g = 0; g < GT_N; g++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) gt[g] <= '0;
      else if (wr && adr == 8'(GT_BASE + g)) gt[g] <= rx;
  end

  assign gt_data = (int'(gt_idx) < GT_N) ? gt[gt_idx] : 8'h00;

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig |=> !sw_trig); // R7
  AST_PCLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ptr_clr |=> !mem_ptr_clr); // R7
  AST_BAD_KEY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_KEY && rx_v && rx != KEY) |=> st == ST_KEY); // R3
  AST_CS_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bcnt == 3'd0); // R4
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_v) |-> $stable(cycle_period)); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_v) |-> $stable(cont_mode)); // R8
  AST_DATA_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DAT && rx_v) |=> st == ST_KEY); // R11

endmodule

// File: tb/spi_cfg_regs_bench.sv
module spi_cfg_regs_bench;
  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic [5:0] gt_idx = 0;
  logic [7:0] gt_data, pulse_on_len, on_off_gap, gain_dac, adc_rate_div, burst_count;
  logic [15:0] pulse_off_len, off_acq_delay, acq_len;
  logic [23:0] cycle_period;
  logic cont_mode, sw_trig, mem_ptr_clr;

  always #10 clk = ~clk;

  spi_cfg_regs u_spi_cfg_regs (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .gt_idx(gt_idx), .gt_data(gt_data), .pulse_on_len(pulse_on_len),
    .on_off_gap(on_off_gap), .pulse_off_len(pulse_off_len),
    .off_acq_delay(off_acq_delay), .acq_len(acq_len),
    .cycle_period(cycle_period), .cont_mode(cont_mode), .gain_dac(gain_dac),
    .adc_rate_div(adc_rate_div), .burst_count(burst_count),
    .sw_trig(sw_trig), .mem_ptr_clr(mem_ptr_clr));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] mreg [256];
  int m_st = 0;
  logic [7:0] m_adr;
  int pend = 0;
  logic [7:0] pend_a, pend_d;
  bit exp_trig, exp_pclr;
  string tag = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    longint e;
    e = mreg[8'hE0];
    check(pulse_on_len == e, tag == "R1" ? "R1" : "R5", "pulse_on_len", pulse_on_len, e);
    e = mreg[8'hD0];
    check(on_off_gap == e, "R5", "on_off_gap", on_off_gap, e);
    e = {mreg[8'hE1], mreg[8'hE2]};
    check(pulse_off_len == e, "R5", "pulse_off_len", pulse_off_len, e);
    e = {mreg[8'hE3], mreg[8'hE4]};
    check(off_acq_delay == e, "R5", "off_acq_delay", off_acq_delay, e);
    e = {mreg[8'hE5], mreg[8'hE6]};
    check(acq_len == e, "R5", "acq_len", acq_len, e);
    e = {mreg[8'hE7], mreg[8'hE8], mreg[8'hE9]};
    check(cycle_period == e, "R6", "cycle_period", cycle_period, e);
    e = mreg[8'hEB][0];
    check(cont_mode == e, "R8", "cont_mode", cont_mode, e);
    e = mreg[8'hEC];
    check(gain_dac == e, "R9", "gain_dac", gain_dac, e);
    e = mreg[8'hED];
    check(adc_rate_div == e, "R9", "adc_rate_div", adc_rate_div, e);
    e = mreg[8'hEE];
    check(burst_count == e, "R9", "burst_count", burst_count, e);
    check(sw_trig == exp_trig, "R7", "sw_trig", sw_trig, exp_trig);
    check(mem_ptr_clr == exp_pclr, "R7", "mem_ptr_clr", mem_ptr_clr, exp_pclr);
    e = (gt_idx <= 6'd40) ? mreg[8'h10 + gt_idx] : 0;
    check(gt_data == e, "R10", "gt_data", gt_data, e);
  endtask

  task automatic tick();
    @(negedge clk);
    exp_trig = 0;
    exp_pclr = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        if (pend_a == 8'hEA) exp_trig = 1;
        else if (pend_a == 8'hEF) exp_pclr = 1;
        else mreg[pend_a] = pend_d;
      end
    end
    if (rst_n) compare();
    gt_idx = gt_idx + 6'd1;
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (m_st)
      0: if (b == 8'hAA) m_st = 1;
      1: begin m_adr = b; m_st = 2; end
      default: begin pend = 4; pend_a = m_adr; pend_d = b; m_st = 0; end
    endcase
  endtask

  task automatic frame(input logic [7:0] b, input int nbits = 8);
    cs_n = 0;
    repeat (3) tick();
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      repeat (4) tick();
      sck = 1;
      if (i == 0) model_byte(b);
      repeat (4) tick();
      sck = 0;
    end
    repeat (2) tick();
    cs_n = 1;
    repeat (5) tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    frame(8'hAA); frame(a); frame(d);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mreg[i] = 8'h00;
    mreg[8'hE0] = 8'h14; mreg[8'hD0] = 8'h0A;
    mreg[8'hE1] = 8'h00; mreg[8'hE2] = 8'hC8;
    mreg[8'hE3] = 8'h02; mreg[8'hE4] = 8'hBC;
    mreg[8'hE5] = 8'h32; mreg[8'hE6] = 8'hC8;
    mreg[8'hE7] = 8'h01; mreg[8'hE8] = 8'h86; mreg[8'hE9] = 8'hA0;
    mreg[8'hEC] = 8'h11; mreg[8'hED] = 8'h03; mreg[8'hEE] = 8'h0A;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset values, compared across a full index sweep
    repeat (70) tick();
    tag = "R5";
    // R2 and R5: basic three-frame writes
    wr(8'hE0, 8'h5A); wr(8'hD0, 8'hC3);
    wr(8'hE1, 8'h12); wr(8'hE2, 8'h34);
    wr(8'hE4, 8'h81); wr(8'hE3, 8'h7E);
    wr(8'hE5, 8'hFF); wr(8'hE6, 8'h00);
    // R6: 24-bit period, each byte separately
    wr(8'hE9, 8'h01); wr(8'hE7, 8'hA5); wr(8'hE8, 8'h5A);
    // R9: single-byte settings
    wr(8'hEC, 8'h80); wr(8'hED, 8'h07); wr(8'hEE, 8'h00);
    // R7: command strobes
    wr(8'hEA, 8'h01); wr(8'hEF, 8'h00); wr(8'hEA, 8'hFF);
    // R8: only bit 0 stored
    wr(8'hEB, 8'h01); wr(8'hEB, 8'hFE); wr(8'hEB, 8'h03);
    // R10: gain table corners
    wr(8'h10, 8'h11); wr(8'h38, 8'hEE); wr(8'h24, 8'h42);
    repeat (70) tick();
    // R3: bytes other than the key are discarded while waiting
    frame(8'h55); frame(8'hE0); frame(8'h77);
    wr(8'hED, 8'h3C);
    // R4: partial bytes discarded in every position of a write
    frame(8'hE0, 5); frame(8'hAA); frame(8'hD0, 3); frame(8'hD0); frame(8'h0F, 7);
    frame(8'h66);
    frame(8'hAA, 4); frame(8'hEC, 6); wr(8'hEC, 8'h29);
    // R11: unmapped addresses ignored, machine back to waiting
    wr(8'h05, 8'h99); wr(8'h39, 8'h98); wr(8'h0F, 8'h97); wr(8'hF0, 8'h96);
    frame(8'hE0);
    wr(8'hE0, 8'hB4);
    repeat (70) tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule